// File: doc/BRIEF.md
# I2C Channel-Select Switch Controller

This block is the digital side of a two-channel bus switch. It behaves as an I2C slave. Its 7-bit address is made of a fixed five-bit prefix followed by two strap pins. It keeps one control byte whose two low bits pick which downstream channels are joined to the upstream bus. Either channel, both channels or neither may be selected. The two enable outputs drive the external pass gates.

The upstream SCL and SDA lines, and two active-low interrupt lines from the downstream segments, are sampled on a fast system clock through two-flop synchronizers. START, STOP and clock edges are detected in that clock domain. A written selection is held pending and is applied only when a STOP is seen. The new connection is therefore made while the bus is idle. A read returns the live interrupt state together with the applied selection. An active-low asynchronous reset drops both channels and returns the protocol engine to idle.

Top module: `i2c_chan_switch`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ch_en_o` is 2'b00 and `sda_oe_o` is 0. A read issued straight after reset returns 0x00 when no interrupt is asserted.
- R2: The device address is {ADDR_PREFIX, strap_i[1], strap_i[0]}, with ADDR_PREFIX = 5'b11100 by default. The eighth bit of the address byte is 1 for read and 0 for write. A matching address is acknowledged by `sda_oe_o` = 1 (SDA pulled low) through the ninth clock.
- R3: On a write, every data byte after the address is acknowledged. Of the bytes received before a STOP, only the last one selects the channels.
- R4: Data bit 0 selects channel 0 (`ch_en_o[0]`) and data bit 1 selects channel 1 (`ch_en_o[1]`). Both may be set at the same time.
- R5: `ch_en_o` changes only when a STOP is detected (SDA rising while SCL is high). It does not change at the end of the data byte or its acknowledge.
- R6: A read shifts out one byte, MSB first. Bits 7, 6, 3 and 2 are 0. Bit 5 is ~irq_n_i[1] and bit 4 is ~irq_n_i[0], taken when the byte is loaded. Bits 1:0 are the applied `ch_en_o`. A master NACK ends the read and releases SDA.
- R7: Data bits 7 to 2 of a write have no effect on `ch_en_o` or on any bit that a read returns.
- R8: After an address mismatch, the block does not acknowledge and keeps SDA released until the next START, and `ch_en_o` does not change at the following STOP.
- R9: A repeated START aborts the byte in progress and restarts address reception. A selection still pending stays pending and is applied only at a later STOP. A read in between returns the old selection.
- R10: Asserting `rst_n` in the middle of a write discards the pending selection, so a later STOP leaves `ch_en_o` at 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Upstream bus clock level |
| sda_i | input | 1 | Upstream bus data level |
| sda_oe_o | output | 1 | 1 pulls upstream SDA low (ACK or read data 0) |
| strap_i | input | 2 | Address strap pins, strap_i[1] above strap_i[0] |
| irq_n_i | input | 2 | Active-low interrupt lines of channels 1 and 0 |
| ch_en_o | output | 2 | Applied channel enables, bit n for channel n |

## Verification
The assertions assume well-formed bus waveforms. SCL and SDA stay at each level for several system clocks. SDA changes while SCL is high only to form a START or a STOP. No other agent drives SDA while the block is acknowledging or sending. The stimulus meets these conditions by building every bit from quarter periods of six clocks: data moves one quarter after SCL falls, and the block's own SDA changes land three clocks after each edge. The interrupt lines change only between transactions, so the status byte can be predicted.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;
  localparam int BYTE_W = 8;
  localparam int CH_N   = 2;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } sw_state_t;

  // true when the received 7-bit address equals prefix followed by straps
  function automatic logic addr_hit(input logic [6:0] rx, input logic [4:0] pfx,
                                    input logic [1:0] strap);
    return rx == {pfx, strap};
  endfunction

  // status byte: zeros, active interrupt flags, zeros, applied selection
  function automatic logic [BYTE_W-1:0] status_byte(input logic [CH_N-1:0] irq_act,
                                                    input logic [CH_N-1:0] sel);
    return {2'b00, irq_act, 2'b00, sel};
  endfunction
endpackage

// File: rtl/i2csw_sync.sv
module i2csw_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2csw_cond.sv
module i2csw_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2csw_engine.sv
module i2csw_engine
  import i2csw_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic            sda_s,
  input  logic [CH_N-1:0] irq_act,
  input  logic [1:0]      strap,
  output logic            sda_oe,
  output logic [CH_N-1:0] sel,
  output sw_state_t       st
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] stat;
  logic [CH_N-1:0]   pend;
  logic              pvld;
  logic              rw;
  logic              mack;

  assign stat = status_byte(irq_act, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; sel <= '0; pend <= '0; pvld <= 1'b0;
    end else if (start_evt) begin
      st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st <= ST_IDLE; sda_oe <= 1'b0;
      if (pvld) sel <= pend;
      pvld <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            if (st == ST_ADDR) begin
              if (addr_hit(sh[7:1], ADDR_PREFIX, strap)) begin
                rw <= sh[0]; sda_oe <= 1'b1; st <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              pend <= sh[CH_N-1:0]; pvld <= 1'b1; sda_oe <= 1'b1; st <= ST_WACK;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt <= '0;
          if (rw) begin
            sh <= stat; sda_oe <= ~stat[BYTE_W-1]; st <= ST_RDAT;
          end else begin
            sda_oe <= 1'b0; st <= ST_WDAT;
          end
        end
        ST_WACK: if (scl_fall) begin
          sda_oe <= 1'b0; cnt <= '0; st <= ST_WDAT;
        end
        ST_RDAT: if (scl_fall) begin
          if (cnt == CNT_LAST) begin
            sda_oe <= 1'b0; st <= ST_RACK;
          end else begin
            sh <= {sh[BYTE_W-2:0], 1'b0};
            sda_oe <= ~sh[BYTE_W-2];
            cnt <= cnt + 1'b1;
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              sh <= stat; sda_oe <= ~stat[BYTE_W-1]; cnt <= '0; st <= ST_RDAT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch
  import i2csw_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11100,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] strap_i,
  input  logic [1:0] irq_n_i,
  output logic [1:0] ch_en_o
);
  localparam int SYNC_W = CH_N + 2;

  logic [SYNC_W-1:0] raw_in, sync_out;
  logic scl_s, sda_s;
  logic [CH_N-1:0] irq_act;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  sw_state_t st;

  assign raw_in = {irq_n_i, sda_i, scl_i};

  i2csw_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  assign scl_s   = sync_out[0];
  assign sda_s   = sync_out[1];
  assign irq_act = ~sync_out[SYNC_W-1:2];

  i2csw_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2csw_engine #(.ADDR_PREFIX(ADDR_PREFIX)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .irq_act(irq_act), .strap(strap_i), .sda_oe(sda_oe_o),
    .sel(ch_en_o), .st(st)
  );
endmodule

// File: rtl/i2c_chan_switch_chk.sv
module i2c_chan_switch_chk
  import i2csw_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic [1:0] ch_en,
  input logic       start_evt,
  input logic       stop_evt,
  input sw_state_t  st
);
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (ch_en == 2'b00 && !sda_oe));

  p_wdat_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_WDAT |-> !sda_oe);

  p_en_only_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_evt |=> $stable(ch_en));

  p_stop_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> st == ST_IDLE);

  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> !sda_oe);

  p_start_to_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> st == ST_ADDR);
endmodule

bind i2c_chan_switch i2c_chan_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .ch_en(ch_en_o),
  .start_evt(start_evt), .stop_evt(stop_evt), .st(st)
);

// File: tb/tb_i2c_chan_switch.sv
module tb_i2c_chan_switch;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic [1:0] irq_n = 2'b11;
  logic sda_oe;
  logic [1:0] ch_en;
  logic sda_line;

  int total = 0;
  int bad = 0;
  logic [1:0] model_en = 2'b00;
  logic [1:0] model_pend = 2'b00;
  bit model_pvld = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_chan_switch dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .irq_n_i(irq_n), .ch_en_o(ch_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the enables against the reference model (R5)
  always @(negedge clk) begin
    #1;
    if (!done) chk(ch_en === model_en, "R5 per-cycle enables", ch_en, model_en);
  end

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; scl = 1'b1; waitq(Q);
    m_sda = 1'b0; waitq(Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; waitq(Q);
    scl = 1'b1; waitq(Q);
    m_sda = 1'b0; waitq(Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq(Q);
    scl = 1'b1; waitq(Q);
    m_sda = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (model_pvld) model_en = model_pend;
    model_pvld = 1'b0;
    waitq(2 * Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; waitq(Q);
    scl = 1'b1; waitq(2 * Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; waitq(Q);
    scl = 1'b1; waitq(Q);
    b = sda_line; waitq(Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic line;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(line);
    acked = (line == 1'b0);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    send_bit(~mack);
  endtask

  function automatic logic [7:0] my_addr(input bit rd);
    return {5'b11100, strap, rd};
  endfunction

  function automatic logic [7:0] exp_status();
    logic [7:0] e = 8'h00;
    e[5] = ~irq_n[1];
    e[4] = ~irq_n[0];
    e[1:0] = model_en;
    return e;
  endfunction

  task automatic write_one(input logic [7:0] v, input string tag);
    bit a;
    bus_start();
    send_byte(my_addr(1'b0), a);
    chk(a, {tag, " R2 address ack"}, a, 1);
    send_byte(v, a);
    chk(a, {tag, " R3 data ack"}, a, 1);
    model_pend = v[1:0]; model_pvld = 1'b1;
    chk(ch_en == model_en, {tag, " R5 no change before stop"}, ch_en, model_en);
    bus_stop();
  endtask

  task automatic read_one(input string tag);
    bit a;
    logic [7:0] got;
    logic [7:0] e;
    bus_start();
    send_byte(my_addr(1'b1), a);
    chk(a, {tag, " R2 read address ack"}, a, 1);
    e = exp_status();
    recv_byte(1'b0, got);
    chk(got == e, {tag, " R6 status byte"}, got, e);
    chk(!sda_oe, {tag, " R6 released after nack"}, sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] got;
    #1 rst_n = 1'b0;
    waitq(5);
    chk(ch_en == 2'b00 && !sda_oe, "R1 reset state", {sda_oe, ch_en}, 0);
    rst_n = 1'b1;
    waitq(5);
    read_one("R1 read after reset");

    write_one(8'h01, "R4 ch0");
    chk(ch_en == 2'b01, "R4 channel 0 enabled", ch_en, 1);
    write_one(8'h03, "R4 both");
    chk(ch_en == 2'b11, "R4 both channels", ch_en, 3);

    // R3: several data bytes, last kept
    bus_start();
    send_byte(my_addr(1'b0), a);
    send_byte(8'h01, a); chk(a, "R3 first byte ack", a, 1);
    send_byte(8'h03, a); chk(a, "R3 second byte ack", a, 1);
    send_byte(8'h02, a); chk(a, "R3 third byte ack", a, 1);
    model_pend = 2'b10; model_pvld = 1'b1;
    bus_stop();
    chk(ch_en == 2'b10, "R3 last byte kept", ch_en, 2);

    // R7: upper bits written have no effect
    write_one(8'hFD, "R7");
    chk(ch_en == 2'b01, "R7 enables from low bits only", ch_en, 1);
    read_one("R7 upper bits not stored");

    // R6: interrupt patterns
    irq_n = 2'b10; waitq(4); read_one("R6 irq0");
    irq_n = 2'b00; waitq(4); read_one("R6 irq both");
    irq_n = 2'b01; waitq(4); read_one("R6 irq1");
    irq_n = 2'b11; waitq(4);

    // R8: mismatched address
    bus_start();
    send_byte({5'b11100, ~strap, 1'b0}, a);
    chk(!a, "R8 no ack on mismatch", a, 0);
    send_byte(8'h02, a);
    chk(!a, "R8 sda released after mismatch", a, 0);
    bus_stop();
    chk(ch_en == 2'b01, "R8 enables unchanged", ch_en, 1);

    // R2: strap change moves the address
    strap = 2'b10; waitq(4);
    write_one(8'h03, "R2 strap 10");
    chk(ch_en == 2'b11, "R2 new strap address works", ch_en, 3);

    // R9: repeated start keeps selection pending; read shows old value
    bus_start();
    send_byte(my_addr(1'b0), a);
    send_byte(8'h02, a);
    model_pend = 2'b10; model_pvld = 1'b1;
    bus_rstart();
    send_byte(my_addr(1'b1), a);
    chk(a, "R9 address after repeated start", a, 1);
    recv_byte(1'b0, got);
    chk(got == 8'h03, "R9 read shows old selection", got, 8'h03);
    bus_stop();
    chk(ch_en == 2'b10, "R9 pending applied at stop", ch_en, 2);

    // R9: abort in the middle of a data byte
    bus_start();
    send_byte(my_addr(1'b0), a);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    bus_rstart();
    send_byte(my_addr(1'b0), a);
    chk(a, "R9 restart after partial byte", a, 1);
    send_byte(8'h01, a);
    model_pend = 2'b01; model_pvld = 1'b1;
    bus_stop();
    chk(ch_en == 2'b01, "R9 partial byte discarded", ch_en, 1);

    // R10: reset with a pending write
    bus_start();
    send_byte(my_addr(1'b0), a);
    send_byte(8'h02, a);
    rst_n = 1'b0; model_en = 2'b00; model_pvld = 1'b0;
    waitq(3);
    chk(ch_en == 2'b00 && !sda_oe, "R10 reset mid write", {sda_oe, ch_en}, 0);
    rst_n = 1'b1; waitq(3);
    bus_stop();
    chk(ch_en == 2'b00, "R10 pending discarded", ch_en, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_200_000;
    done = 1'b1;
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule